// File: doc/BRIEF.md
# Priority-Gated Error Address Capture Register

This block is a 64-bit status register that holds the location of the most severe cache error seen since it was last cleared. An error source presents a one-cycle pulse together with a priority code, the cache way that failed, virtual index bits 15:13 and physical line address bits 42:6. The stored priority field acts as the gate for new records. A new error replaces the record only when its priority is strictly above the stored one. A stored priority of zero means the register is empty.

Software reads the packed word through a registered read port. Any write strobe empties the register, and no write data is involved. One even parity bit covers the stored word. It is recomputed each time the record changes and checked on every read. The power-on reset clears the record. The soft reset leaves the record alone and only clears the read return path.

Top module: `errcap_reg`

## Requirements
- R1: The priority code of the held error sits in bits WORD_W-1 down to WORD_W-PRIO_W, which are 63:56 by default. Priority 0 means no error is held, and an empty register reads as all zeros.
- R2: A pulse on `err_valid` is recorded only when `err_prio` is strictly greater than the stored priority. When the stored priority is greater than or equal to `err_prio`, the whole word stays unchanged.
- R3: A recorded error replaces every field at once: priority, way, virtual index and physical address all come from the same pulse.
- R4: Bit 55 holds the way, bits 50:48 hold virtual address bits 15:13, and bits 42:6 hold physical address bits 42:6.
- R5: Every bit outside the priority, way, virtual-index and physical-address fields always reads as 0.
- R6: A `sw_wr` strobe sets the whole word to 0 on the next edge, whatever was held. The emptied register then accepts any error with a priority of 1 or more.
- R7: While `soft_rst_n` is low, the held record is kept, and the read outputs are forced to 0 on each edge.
- R8: A parity bit is stored with the word, using even parity over all 64 bits, and is updated on every capture and clear. `rd_par_err` rises on a read only when the recomputed parity differs from the stored bit.
- R9: When `sw_wr` and an accepted `err_valid` fall in the same cycle, the write wins and the word ends at 0.
- R10: A low level on `por_n` clears the record, the parity bit and the read outputs asynchronously.
- R11: A `sw_rd` strobe loads `rd_data` and `rd_par_err` on that clock edge with the word held before the edge. These outputs then hold until the next read or soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous, keeps the record |
| err_valid | input | 1 | One-cycle pulse announcing a new error |
| err_prio | input | PRIO_W | Priority code of the new error |
| err_way | input | 1 | Cache way of the new error |
| err_va | input | VA_W | Virtual address bits 15:13 of the failing line |
| err_pa | input | PA_W | Physical address bits 42:6 of the failing line |
| sw_wr | input | 1 | Software write strobe, clears the register |
| sw_rd | input | 1 | Software read strobe |
| rd_data | output | WORD_W | Packed word returned by the last read |
| rd_par_err | output | 1 | Parity mismatch seen by the last read |

## Verification
The bench builds the block with PRIO_W = 4, so the priority occupies bits 63:60 and bits 59:56 turn into reserved bits that must read as zero. With only 16 priority codes, every pairing of a stored priority with an incoming one can be applied in a short run. This covers the equal, one-above and one-below cases and the empty register. Each pair is preceded by a clear, and each result is compared as a whole 64-bit word. On top of the sweep, directed cases cover a write colliding with a capture, a read in the same cycle as a write, a soft reset around a held record, and a power-on reset.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_CLEAR   = 2'd1,
        UPD_CAPTURE = 2'd2
    } upd_e;

endpackage

// File: rtl/errcap_gate.sv
module errcap_gate
    import errcap_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              err_valid,
    input  logic [PRIO_W-1:0] err_prio,
    input  logic [PRIO_W-1:0] held_prio,
    input  logic              sw_wr,
    output upd_e              action
);

    logic outranks;

    always_comb begin
        outranks = err_valid && (err_prio > held_prio);
        if (sw_wr) begin
            action = UPD_CLEAR;
        end else if (outranks) begin
            action = UPD_CAPTURE;
        end else begin
            action = UPD_HOLD;
        end
    end

endmodule

// File: rtl/errcap_pack.sv
module errcap_pack #(
    parameter int WORD_W  = 64,
    parameter int PRIO_W  = 8,
    parameter int VA_W    = 3,
    parameter int PA_W    = 37,
    parameter int WAY_POS = 55,
    parameter int VA_LSB  = 48,
    parameter int PA_LSB  = 6
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic              way,
    input  logic [VA_W-1:0]   va,
    input  logic [PA_W-1:0]   pa,
    output logic [WORD_W-1:0] word
);

    localparam int PRIO_LSB = WORD_W - PRIO_W;

    always_comb begin
        word                     = '0;
        word[PRIO_LSB +: PRIO_W] = prio;
        word[WAY_POS]            = way;
        word[VA_LSB +: VA_W]     = va;
        word[PA_LSB +: PA_W]     = pa;
    end

endmodule

// File: rtl/errcap_parity.sv
module errcap_parity #(
    parameter int W = 64
) (
    input  logic [W-1:0] data,
    output logic         par
);

    always_comb begin
        par = ^data;
    end

endmodule

// File: rtl/errcap_reg.sv
module errcap_reg
    import errcap_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int PRIO_W  = 8,
    parameter int VA_W    = 3,
    parameter int PA_W    = 37,
    parameter int WAY_POS = 55,
    parameter int VA_LSB  = 48,
    parameter int PA_LSB  = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic              err_valid,
    input  logic [PRIO_W-1:0] err_prio,
    input  logic              err_way,
    input  logic [VA_W-1:0]   err_va,
    input  logic [PA_W-1:0]   err_pa,
    input  logic              sw_wr,
    input  logic              sw_rd,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_par_err
);

    localparam int PRIO_LSB = WORD_W - PRIO_W;
    localparam logic [WORD_W-1:0] FIELD_MASK =
        ({WORD_W{1'b0}} | ({{(WORD_W-PRIO_W){1'b0}}, {PRIO_W{1'b1}}} << PRIO_LSB))
        | (({{(WORD_W-1){1'b0}}, 1'b1}) << WAY_POS)
        | ({{(WORD_W-VA_W){1'b0}}, {VA_W{1'b1}}} << VA_LSB)
        | ({{(WORD_W-PA_W){1'b0}}, {PA_W{1'b1}}} << PA_LSB);

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              way;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   pa;
    } rec_t;

    typedef struct packed {
        rec_t              rec;
        logic              par;
        logic [WORD_W-1:0] rd;
        logic              rd_err;
    } state_t;

    state_t            st_d, st_q;
    rec_t              rec_d;
    upd_e              action;
    logic [WORD_W-1:0] word_q, word_d;
    logic              par_now, par_d;

    errcap_gate #(.PRIO_W(PRIO_W)) u_gate (
        .err_valid (err_valid),
        .err_prio  (err_prio),
        .held_prio (st_q.rec.prio),
        .sw_wr     (sw_wr),
        .action    (action)
    );

    errcap_pack #(
        .WORD_W(WORD_W), .PRIO_W(PRIO_W), .VA_W(VA_W), .PA_W(PA_W),
        .WAY_POS(WAY_POS), .VA_LSB(VA_LSB), .PA_LSB(PA_LSB)
    ) u_pack_q (
        .prio (st_q.rec.prio),
        .way  (st_q.rec.way),
        .va   (st_q.rec.va),
        .pa   (st_q.rec.pa),
        .word (word_q)
    );

    errcap_pack #(
        .WORD_W(WORD_W), .PRIO_W(PRIO_W), .VA_W(VA_W), .PA_W(PA_W),
        .WAY_POS(WAY_POS), .VA_LSB(VA_LSB), .PA_LSB(PA_LSB)
    ) u_pack_d (
        .prio (rec_d.prio),
        .way  (rec_d.way),
        .va   (rec_d.va),
        .pa   (rec_d.pa),
        .word (word_d)
    );

    errcap_parity #(.W(WORD_W)) u_par_q (.data(word_q), .par(par_now));
    errcap_parity #(.W(WORD_W)) u_par_d (.data(word_d), .par(par_d));

    // Next record: clear, capture or hold, chosen by the gate.
    always_comb begin
        rec_d = st_q.rec;
        unique case (action)
            UPD_CLEAR:   rec_d = '0;
            UPD_CAPTURE: begin
                rec_d.prio = err_prio;
                rec_d.way  = err_way;
                rec_d.va   = err_va;
                rec_d.pa   = err_pa;
            end
            default:     rec_d = st_q.rec;
        endcase
    end

    // Full next state, including parity and the read return path.
    always_comb begin
        st_d     = st_q;
        st_d.rec = rec_d;
        st_d.par = par_d;
        if (!soft_rst_n) begin
            st_d.rd     = '0;
            st_d.rd_err = 1'b0;
        end else if (sw_rd) begin
            st_d.rd     = word_q;
            st_d.rd_err = (par_now != st_q.par);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rd;
    assign rd_par_err = st_q.rd_err;

    // R2: a pulse that does not outrank the record leaves the word alone.
    p_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        (!sw_wr && !(err_valid && (err_prio > word_q[PRIO_LSB +: PRIO_W])))
        |=> $stable(word_q));

    // R3: an outranking pulse becomes the stored priority.
    p_capture_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!sw_wr && err_valid && (err_prio > word_q[PRIO_LSB +: PRIO_W]))
        |=> (word_q[PRIO_LSB +: PRIO_W] == $past(err_prio)));

    // R6, R9: a write empties the word, even alongside a capture.
    p_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
        sw_wr |=> (word_q == '0));

    // R5: bits outside the fields never carry data.
    p_reserved_r5: assert property (@(posedge clk) disable iff (!por_n)
        ((word_q & ~FIELD_MASK) == '0));

    // R8: with intact storage a read never reports a parity mismatch.
    p_parity_r8: assert property (@(posedge clk) disable iff (!por_n)
        sw_rd |=> !rd_par_err);

    // R7: soft reset empties the read return path and nothing else.
    p_soft_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst_n && !sw_wr && !err_valid)
        |=> (rd_data == '0 && !rd_par_err && $stable(word_q)));

endmodule

// File: tb/tb_errcap_reg.sv
module tb_errcap_reg;

    localparam int WORD_W = 64;
    localparam int PRIO_W = 4;
    localparam int VA_W   = 3;
    localparam int PA_W   = 37;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              soft_rst_n = 1'b1;
    logic              err_valid = 1'b0;
    logic [PRIO_W-1:0] err_prio = '0;
    logic              err_way = 1'b0;
    logic [VA_W-1:0]   err_va = '0;
    logic [PA_W-1:0]   err_pa = '0;
    logic              sw_wr = 1'b0;
    logic              sw_rd = 1'b0;
    logic [WORD_W-1:0] rd_data;
    logic              rd_par_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    errcap_reg #(.WORD_W(WORD_W), .PRIO_W(PRIO_W), .VA_W(VA_W), .PA_W(PA_W)) dut (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
        .err_valid(err_valid), .err_prio(err_prio), .err_way(err_way),
        .err_va(err_va), .err_pa(err_pa), .sw_wr(sw_wr), .sw_rd(sw_rd),
        .rd_data(rd_data), .rd_par_err(rd_par_err)
    );

    function automatic logic [WORD_W-1:0] pack(input logic [PRIO_W-1:0] p,
                                               input logic w,
                                               input logic [VA_W-1:0] v,
                                               input logic [PA_W-1:0] a);
        return (64'(p) << 60) | (64'(w) << 55) | (64'(v) << 48) | (64'(a) << 6);
    endfunction

    task automatic check(input string tag, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_err(input logic [PRIO_W-1:0] p, input logic w,
                             input logic [VA_W-1:0] v, input logic [PA_W-1:0] a,
                             input logic wr);
        err_valid = 1'b1; err_prio = p; err_way = w; err_va = v; err_pa = a;
        sw_wr = wr;
        @(negedge clk);
        err_valid = 1'b0; sw_wr = 1'b0;
    endtask

    task automatic do_write();
        sw_wr = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic do_read();
        sw_rd = 1'b1;
        @(negedge clk);
        sw_rd = 1'b0;
    endtask

    initial begin
        logic [WORD_W-1:0] exp_a, exp_b, exp;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1, R10: empty after power-on reset
        do_read();
        check("R1 reset word", rd_data, '0);
        check("R8 reset parity", 64'(rd_par_err), '0);

        // R2, R3, R4, R5, R6: all pairs of held and incoming priority
        for (int s = 0; s < 16; s++) begin
            for (int n = 0; n < 16; n++) begin
                logic wa, wb;
                logic [VA_W-1:0] va, vb;
                logic [PA_W-1:0] pa, pb;
                wa = s[0];  va = 3'(s) ^ 3'd5;  pa = 37'(s) * 37'd98765 + 37'd12345;
                wb = ~n[0]; vb = 3'(n);         pb = 37'(n) * 37'd4321 + 37'h10_0000_0003;
                do_write();
                pulse_err(4'(s), wa, va, pa, 1'b0);
                pulse_err(4'(n), wb, vb, pb, 1'b0);
                do_read();
                exp_a = (s > 0) ? pack(4'(s), wa, va, pa) : '0;
                exp_b = pack(4'(n), wb, vb, pb);
                exp = (n > s) ? exp_b : exp_a;
                check("R2 R3 R4 R5 R6 sweep", rd_data, exp);
                if (rd_par_err) check("R8 sweep parity", 64'(rd_par_err), '0);
            end
        end

        // R9: write beats a same-cycle capture
        do_write();
        pulse_err(4'd15, 1'b1, 3'd7, '1, 1'b1);
        do_read();
        check("R9 write wins", rd_data, '0);

        // R11: read in the same cycle as a write returns the old word
        pulse_err(4'd6, 1'b1, 3'd2, 37'h0_1234_5678, 1'b0);
        sw_rd = 1'b1; sw_wr = 1'b1;
        @(negedge clk);
        sw_rd = 1'b0; sw_wr = 1'b0;
        check("R11 read before write", rd_data, pack(4'd6, 1'b1, 3'd2, 37'h0_1234_5678));
        @(negedge clk);
        check("R11 read holds", rd_data, pack(4'd6, 1'b1, 3'd2, 37'h0_1234_5678));
        do_read();
        check("R6 cleared after write", rd_data, '0);

        // R7: soft reset keeps the record, clears the read path
        pulse_err(4'd9, 1'b0, 3'd5, 37'h1F_FFFF_FFFF, 1'b0);
        do_read();
        check("R7 before soft reset", rd_data, pack(4'd9, 1'b0, 3'd5, 37'h1F_FFFF_FFFF));
        soft_rst_n = 1'b0;
        sw_rd = 1'b1;
        @(negedge clk);
        sw_rd = 1'b0;
        @(negedge clk);
        check("R7 read path cleared", rd_data, '0);
        soft_rst_n = 1'b1;
        do_read();
        check("R7 record kept", rd_data, pack(4'd9, 1'b0, 3'd5, 37'h1F_FFFF_FFFF));
        check("R8 parity after soft reset", 64'(rd_par_err), '0);

        // R10: power-on reset clears the record
        #2 por_n = 1'b0;
        #3 check("R10 read path cleared", rd_data, '0);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        do_read();
        check("R10 record cleared", rd_data, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule